// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block stamps the time of an external event. A free-running 16-bit time base advances from the module clock through a power-of-two prescaler, and only while its run bit is set. One capture channel watches an asynchronous input pin. The pin passes through a two-stage synchroniser and an edge detector. When the chosen kind of edge appears, the current time-base value is copied into a 16-bit capture register and a sticky flag is raised. An interrupt request follows the flag whenever the channel's mask bit is set.

Software configures the block through a small write-only register port. It reads the time base, the capture register, the flag and the interrupt request directly from output ports. It clears the flag by writing a one to it. Subtracting two captures modulo 2^16 gives a period or a pulse width, even when the time base has wrapped between the two captures.

Top module: `cap_timer`

## Requirements
- R1: The time base holds its value while the run bit (address 0, bit 0) is 0. It advances by exactly one per tick while the run bit is 1. After reset the time base is 0, the capture register is 0, and the flag and interrupt request are low.
- R2: The prescale field PR (address 0, bits 3:1, values 0 to 7) makes the time base advance once every 2^PR module clocks. Any write to address 0 restarts the prescale phase.
- R3: Edge code 00 (address 1, bits 1:0) disables capture. No pin edge changes the flag or the capture register.
- R4: Edge code 01 captures on rising pin edges only.
- R5: Edge code 10 captures on falling pin edges only.
- R6: Edge code 11 captures on both rising and falling pin edges.
- R7: A capture stores the time-base value present in the cycle when the synchronised edge is seen. A pin change set up before clock edge k is latched on clock edge k+2.
- R8: A capture sets the flag. Writing address 2 with bit 0 = 1 clears the flag. Writing address 2 with bit 0 = 0 leaves the flag unchanged.
- R9: When a capture and a flag-clear write fall on the same clock edge, the flag ends up set.
- R10: The interrupt request is high exactly when the flag is set and the mask bit (address 1, bit 2) is 1.
- R11: A qualifying edge that arrives while the flag is still set overwrites the capture register with the newer time value.
- R12: With the time base running at a fixed rate, the difference of two captures taken D ticks apart equals D modulo 2^16, including across a wrap of the time base.
- R13: In both-edge mode, a pin pulse lasting three module clocks yields two captures whose difference is three ticks at PR = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 channel setup, 2 flag clear) |
| wr_data | input | 8 | Register write data |
| pin_i | input | 1 | Asynchronous event pin |
| count_o | output | 16 | Current time-base value |
| capture_o | output | 16 | Last captured time value |
| flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions of the flag can meet on one clock edge: a capture that sets it, and a software write that clears it. The bench raises the pin, then times the clear write so that it lands on the second clock edge after the pin was sampled, which is the edge on which the capture takes place. The flag must read high after that edge. A clear write on the following edge must then bring the flag low. The same timing model places every capture in the sweeps over edge codes and prescale settings, so a design that adds or drops a synchroniser stage is caught by the captured values.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CNT_W = 16;
  localparam int PR_W  = 3;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  // Decide whether a detected transition qualifies under the selected code.
  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    logic hit;
    unique case (sel)
      SEL_OFF:  hit = 1'b0;
      SEL_RISE: hit = rise;
      SEL_FALL: hit = fall;
      SEL_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 16,
  parameter int PR_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PR_W-1:0]  pr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PR_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] count_q;

  // A tick is due when the low PR bits of the divider are all ones.
  function automatic logic tick_due(logic [DIV_W-1:0] div, logic [PR_W-1:0] pr);
    logic [DIV_W-1:0] m;
    m = (DIV_W'(1) << pr) - DIV_W'(1);
    return (div & m) == m;
  endfunction

  assign tick_o  = run_i && !restart_i && tick_due(div_q, pr_i);
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      count_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
    end else if (run_i) begin
      div_q <= div_q + DIV_W'(1);
      if (tick_o) count_q <= count_q + CNT_W'(1);
    end
  end

  assert_hold_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(count_o));
  assert_step_of_one_R1: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> count_o == $past(count_o) + CNT_W'(1));
  assert_restart_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> $stable(count_o));
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise_o = sync_q[1] & ~prev_q;
  assign fall_o = ~sync_q[1] & prev_q;

  assert_rise_not_repeated_R4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  assert_fall_not_repeated_R5: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  edge_sel_e        sel_i,
  input  logic             mask_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] capture_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  assign evt_o = edge_hit(sel_i, rise_i, fall_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (evt_o) cap_q <= count_i;
      // A new capture outranks a clear in the same cycle.
      if (evt_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign capture_o = cap_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & mask_i;

  assert_latch_time_R7: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> capture_o == $past(count_i));
  assert_flag_after_capture_R9: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> flag_o);
  assert_clear_alone_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt_o) |=> !flag_o);
  assert_capture_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !evt_o |=> $stable(capture_o));
  assert_off_never_captures_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SEL_OFF) |-> !evt_o);
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o && mask_i);
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             pin_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SETUP = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;

  logic            run_q;
  logic [PR_W-1:0] pr_q;
  edge_sel_e       sel_q;
  logic            mask_q;

  logic ctrl_wr, flag_clr, tick, rise, fall, cap_evt;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign flag_clr = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pr_q   <= '0;
      sel_q  <= SEL_OFF;
      mask_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) begin
        run_q <= wr_data[0];
        pr_q  <= wr_data[PR_W:1];
      end
      if (wr_addr == ADDR_SETUP) begin
        sel_q  <= edge_sel_e'(wr_data[1:0]);
        mask_q <= wr_data[2];
      end
    end
  end

  cap_timebase #(.CNT_W(CNT_W), .PR_W(PR_W)) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_q),
    .pr_i      (pr_q),
    .restart_i (ctrl_wr),
    .count_o   (count_o),
    .tick_o    (tick)
  );

  cap_edge_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  cap_channel #(.CNT_W(CNT_W)) u_channel (
    .clk       (clk),
    .rst       (rst),
    .count_i   (count_o),
    .rise_i    (rise),
    .fall_i    (fall),
    .sel_i     (sel_q),
    .mask_i    (mask_q),
    .clr_i     (flag_clr),
    .capture_o (capture_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .evt_o     (cap_evt)
  );

  assert_stopped_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !tick);
  assert_zero_write_keeps_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr) |=> flag_o);
endmodule

// File: tb/cap_timer_tb.sv
module cap_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pin_i = 1'b0;
  logic [15:0] count_o, capture_o;
  logic        flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_i(pin_i), .count_o(count_o), .capture_o(capture_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Run the time base n clocks at PR=0, then stop it.
  task automatic advance(input int n);
    wr(2'd0, 8'h01);
    repeat (n) @(negedge clk);
    wr(2'd0, 8'h00);
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk);
    pin_i = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c1, c2, frozen, prev_cap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(count_o == 0, "R1 reset count", count_o, 0);
    check(capture_o == 0, "R1 reset capture", capture_o, 0);
    check(flag_o == 0 && irq_o == 0, "R1 reset flag/irq", {flag_o, irq_o}, 0);

    // R1 hold while stopped
    c1 = count_o;
    repeat (50) @(negedge clk);
    check(count_o == c1, "R1 hold while stopped", count_o, c1);

    // R2 prescale sweep
    for (int pr = 0; pr < 8; pr++) begin
      wr(2'd0, 8'(1 | (pr << 1)));
      c1 = count_o;
      repeat (5 << pr) @(negedge clk);
      c2 = count_o;
      check(16'(c2 - c1) == 16'd5, $sformatf("R2 prescale PR=%0d", pr), 16'(c2 - c1), 5);
    end
    wr(2'd0, 8'h00);
    c1 = count_o;
    repeat (20) @(negedge clk);
    check(count_o == c1, "R1 stop after run", count_o, c1);

    // R3..R7 edge-code sweep with a frozen time base
    for (int sel = 0; sel < 4; sel++) begin
      for (int pol = 1; pol >= 0; pol--) begin
        wr(2'd1, 8'(sel));
        wr(2'd2, 8'h01);
        advance(sel * 3 + pol + 2);
        frozen = count_o;
        prev_cap = capture_o;
        drive_pin(pol[0]);
        if ((pol == 1 && (sel == 1 || sel == 3)) || (pol == 0 && (sel == 2 || sel == 3))) begin
          check(flag_o == 1, $sformatf("R4 R5 R6 flag sel=%0d rise=%0d", sel, pol), flag_o, 1);
          check(capture_o == frozen, $sformatf("R7 capture sel=%0d rise=%0d", sel, pol),
                capture_o, frozen);
        end else begin
          check(flag_o == 0, $sformatf("R3 R4 R5 no flag sel=%0d rise=%0d", sel, pol), flag_o, 0);
          check(capture_o == prev_cap, $sformatf("R3 capture kept sel=%0d rise=%0d", sel, pol),
                capture_o, prev_cap);
        end
      end
    end

    // R8 write-0 keeps, write-1 clears; R11 overwrite while flag set
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h01);
    advance(7);
    drive_pin(1'b1);
    check(flag_o == 1, "R8 flag set", flag_o, 1);
    wr(2'd2, 8'h00);
    check(flag_o == 1, "R8 write 0 keeps flag", flag_o, 1);
    advance(9);
    frozen = count_o;
    drive_pin(1'b0);
    check(capture_o == frozen, "R11 overwrite with newer value", capture_o, frozen);
    check(flag_o == 1, "R11 flag still set", flag_o, 1);

    // R10 interrupt gating
    wr(2'd1, 8'h03);
    check(irq_o == 0, "R10 masked", irq_o, 0);
    wr(2'd1, 8'h07);
    check(irq_o == 1, "R10 unmasked with flag", irq_o, 1);
    wr(2'd2, 8'h01);
    check(flag_o == 0, "R8 write 1 clears", flag_o, 0);
    check(irq_o == 0, "R10 no flag no irq", irq_o, 0);

    // R9 capture and clear on the same edge
    @(negedge clk);
    pin_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
    @(negedge clk);
    check(flag_o == 1, "R9 set wins over clear", flag_o, 1);
    @(negedge clk);
    wr_en = 1'b0;
    check(flag_o == 0, "R9 later clear takes effect", flag_o, 0);
    drive_pin(1'b0);
    wr(2'd2, 8'h01);

    // R13 three-clock pulse, both edges, time base running
    wr(2'd0, 8'h01);
    @(negedge clk);
    pin_i = 1'b1;
    repeat (3) @(negedge clk);
    c1 = capture_o;
    pin_i = 1'b0;
    repeat (4) @(negedge clk);
    c2 = capture_o;
    check(16'(c2 - c1) == 16'd3, "R13 short pulse width", 16'(c2 - c1), 3);

    // R12 period across wrap, rising only
    wr(2'd1, 8'h01);
    foreach (c1[i]) ; // no-op keeps variable use simple
    for (int t = 0; t < 3; t++) begin
      int d;
      int pr;
      d  = (t == 0) ? 1000 : (t == 1) ? 70000 : 800;
      pr = (t == 2) ? 3 : 0;
      wr(2'd0, 8'(1 | (pr << 1)));
      @(negedge clk);
      pin_i = 1'b1;
      repeat (4) @(negedge clk);
      pin_i = 1'b0;
      c1 = capture_o;
      repeat (d - 4) @(negedge clk);
      pin_i = 1'b1;
      repeat (4) @(negedge clk);
      pin_i = 1'b0;
      c2 = capture_o;
      check(16'(c2 - c1) == 16'((d >> pr) % 65536), $sformatf("R12 period d=%0d pr=%0d", d, pr),
            16'(c2 - c1), 16'((d >> pr) % 65536));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule